// File: doc/BRIEF.md
# Dynamic Bus Sizing Lane Steering

This block sits between a 32-bit bus master and an external port whose width may be 32, 16 or 8 bits. One access request, a full word plus a port width code, becomes one, two or four back-to-back external transfers. For each transfer the block places the right bytes on the external lanes and asserts the matching active-low byte selects. It also presents the low address bits of that transfer and waits for an acknowledge before moving on.

Narrow ports always occupy the most significant lanes. A 16-bit port uses the upper half-word lanes and an 8-bit port uses the top byte lane. Lanes a narrow port does not use are driven to zero. Read data returned on the active lanes is gathered into its byte positions of a 32-bit result. That result is presented with a one-cycle done pulse after the final acknowledge.

Byte numbering is big-endian. Byte 0 is bits 31:24 of the word, byte 3 is bits 7:0, and external lane j occupies bits 31-8j down to 24-8j.

Top module: `bus_sizer`

## Requirements
- R1: After reset, xfer_o is 0, bs_n_o is 4'b1111, addr_o, wr_lanes_o and rdata_o are 0, and done_o is 0.
- R2: A start_i seen while idle is captured together with wdata_i and psize_i. The first transfer appears on the next cycle with addr_o = 0. A start_i seen while a transfer is in progress is ignored.
- R3: With psize_i = 2'b00 (32-bit port), a single transfer drives wr_lanes_o equal to the captured word, bs_n_o = 4'b0000 and addr_o = 0.
- R4: With psize_i = 2'b01 (16-bit port), there are two transfers. The first carries bytes 0–1 on bits 31:16 at addr_o = 0. The second carries bytes 2–3 on bits 31:16 at addr_o = 2. Both use bs_n_o = 4'b0011 and drive bits 15:0 to zero.
- R5: With psize_i = 2'b10 (8-bit port), there are four transfers. Transfer k carries byte k on bits 31:24 at addr_o = k, with bs_n_o = 4'b0111 and bits 23:0 driven to zero.
- R6: psize_i = 2'b11 is handled exactly like a 32-bit port.
- R7: While xfer_o is 1 and ack_i is 0, wr_lanes_o, bs_n_o and addr_o hold their values. The transfer advances only on a cycle where ack_i is 1.
- R8: On each acknowledged transfer, the active lanes of rd_lanes_i are stored into the byte positions that transfer carries. For a 32-bit port that is the whole word. For a 16-bit port, bits 31:16 go to result bits 31:16 and then 15:0. For an 8-bit port, bits 31:24 go to byte k. Inactive lanes are ignored.
- R9: done_o is high for exactly one cycle, the cycle after the last acknowledge. rdata_o then shows the assembled word and keeps it until the next accepted start.
- R10: While idle, bs_n_o is 4'b1111 and wr_lanes_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new access (taken only while idle) |
| psize_i | input | 2 | Port width code: 00 32-bit, 01 16-bit, 10 8-bit, 11 32-bit |
| wdata_i | input | 32 | Word to write, captured with start_i |
| ack_i | input | 1 | Current external transfer complete |
| rd_lanes_i | input | 32 | Read data on the external lanes |
| xfer_o | output | 1 | An external transfer is active |
| wr_lanes_o | output | 32 | Write data on the external lanes |
| bs_n_o | output | 4 | Active-low byte selects, bit 3 for lane bits 31:24 |
| addr_o | output | 2 | Low address bits of the current transfer |
| done_o | output | 1 | One-cycle pulse when the access finishes |
| rdata_o | output | 32 | Assembled read word |

## Verification
Some properties are checked on every cycle. An idle block keeps its byte selects off and its lanes quiet. A stalled transfer keeps its lanes, selects and address. Every transfer sequence starts at address 0. An 8-bit port enables only the top lane, and a 16-bit port leaves the low half at zero. The done pulse lasts one cycle and always follows an acknowledged transfer. Only the bench's reference model can show that the right bytes land on the right lanes in the right order. The same goes for read bytes reaching their result positions, the reserved width code acting as 32-bit, and a start during a busy access leaving no trace.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
    typedef enum logic [1:0] {
        PS_W32  = 2'b00,
        PS_W16  = 2'b01,
        PS_W8   = 2'b10,
        PS_W32R = 2'b11
    } port_size_e;
endpackage

// File: rtl/bsz_size_decode.sv
module bsz_size_decode #(
    parameter int NB = 4,
    parameter int AW = 2
) (
    input  bsz_pkg::port_size_e size_i,
    output logic [AW:0]         wb_o,
    output logic [AW-1:0]       last_o
);
    always_comb begin
        unique case (size_i)
            bsz_pkg::PS_W16: begin
                wb_o   = (AW+1)'(NB/2);
                last_o = AW'(1);
            end
            bsz_pkg::PS_W8: begin
                wb_o   = (AW+1)'(1);
                last_o = AW'(NB-1);
            end
            default: begin
                wb_o   = (AW+1)'(NB);
                last_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/bsz_lane_mux.sv
module bsz_lane_mux #(
    parameter int DW = 32,
    parameter int NB = DW/8,
    parameter int AW = 2
) (
    input  logic          active_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW:0]   wb_i,
    input  logic [AW-1:0] idx_i,
    output logic [DW-1:0] lanes_o,
    output logic [NB-1:0] bs_n_o,
    output logic [AW-1:0] addr_o
);
    int base;

    always_comb begin
        base    = int'(idx_i) * int'(wb_i);
        lanes_o = '0;
        bs_n_o  = '1;
        addr_o  = '0;
        if (active_i) begin
            addr_o = AW'(base);
            for (int j = 0; j < NB; j++) begin
                if (j < int'(wb_i) && (base + j) < NB) begin
                    lanes_o[DW-1-8*j -: 8] = wdata_i[DW-1-8*(base+j) -: 8];
                    bs_n_o[NB-1-j]         = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/bsz_read_merge.sv
module bsz_read_merge #(
    parameter int DW = 32,
    parameter int NB = DW/8,
    parameter int AW = 2
) (
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] lanes_i,
    input  logic [AW:0]   wb_i,
    input  logic [AW-1:0] idx_i,
    output logic [DW-1:0] rdata_o
);
    int base;

    always_comb begin
        base    = int'(idx_i) * int'(wb_i);
        rdata_o = rdata_i;
        for (int j = 0; j < NB; j++) begin
            if (j < int'(wb_i) && (base + j) < NB) begin
                rdata_o[DW-1-8*(base+j) -: 8] = lanes_i[DW-1-8*j -: 8];
            end
        end
    end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer #(
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [1:0]               psize_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic                     ack_i,
    input  logic [DW-1:0]            rd_lanes_i,
    output logic                     xfer_o,
    output logic [DW-1:0]            wr_lanes_o,
    output logic [DW/8-1:0]          bs_n_o,
    output logic [$clog2(DW/8)-1:0]  addr_o,
    output logic                     done_o,
    output logic [DW-1:0]            rdata_o
);
    localparam int NB = DW/8;
    localparam int AW = $clog2(NB);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] idx;
        logic [1:0]    size;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
    } seq_t;

    seq_t st_d, st_q;

    logic [AW:0]   wb;
    logic [AW-1:0] last_idx;
    logic [DW-1:0] merged;

    bsz_size_decode #(.NB(NB), .AW(AW)) i_dec (
        .size_i (bsz_pkg::port_size_e'(st_q.size)),
        .wb_o   (wb),
        .last_o (last_idx)
    );

    bsz_lane_mux #(.DW(DW), .NB(NB), .AW(AW)) i_mux (
        .active_i (st_q.busy),
        .wdata_i  (st_q.wdata),
        .wb_i     (wb),
        .idx_i    (st_q.idx),
        .lanes_o  (wr_lanes_o),
        .bs_n_o   (bs_n_o),
        .addr_o   (addr_o)
    );

    bsz_read_merge #(.DW(DW), .NB(NB), .AW(AW)) i_merge (
        .rdata_i (st_q.rdata),
        .lanes_i (rd_lanes_i),
        .wb_i    (wb),
        .idx_i   (st_q.idx),
        .rdata_o (merged)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                st_d.size  = psize_i;
                st_d.wdata = wdata_i;
                st_d.rdata = '0;
            end
        end else if (ack_i) begin
            st_d.rdata = merged;
            if (st_q.idx == last_idx) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xfer_o  = st_q.busy;
    assign done_o  = st_q.done;
    assign rdata_o = st_q.rdata;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_o |-> (bs_n_o == '1 && wr_lanes_o == '0));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && !ack_i) |=> (xfer_o && $stable(addr_o) && $stable(bs_n_o) && $stable(wr_lanes_o)));

    assert_first_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_o) |-> addr_o == '0);

    assert_byte_port_top_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && st_q.size == 2'b10) |-> bs_n_o == {1'b0, {(NB-1){1'b1}}});

    assert_half_port_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && st_q.size == 2'b01) |-> wr_lanes_o[DW/2-1:0] == '0);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(xfer_o && ack_i));
endmodule

// File: tb/test_bus_sizer.sv
module test_bus_sizer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  psize;
    logic [31:0] wdata;
    logic        ack;
    logic [31:0] d_in;
    logic        xfer;
    logic [31:0] lanes;
    logic [3:0]  bs_n;
    logic [1:0]  addr;
    logic        done;
    logic [31:0] rdata;

    always #2 clk = ~clk;

    bus_sizer i_bus_sizer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .psize_i(psize),
        .wdata_i(wdata), .ack_i(ack), .rd_lanes_i(d_in), .xfer_o(xfer),
        .wr_lanes_o(lanes), .bs_n_o(bs_n), .addr_o(addr), .done_o(done),
        .rdata_o(rdata)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] d;
        logic [3:0]  bs;
        logic [1:0]  a;
    } xr_t;

    xr_t         mq[$];
    int          m_k;
    int          m_sz;
    logic [31:0] m_r;
    logic        m_done;

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string wtag();
        if (!rst_n) return "R1";
        if (mq.size() == 0) return "R10";
        case (m_sz)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Reference model, updated on the same edge the design samples
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_r = 0; m_done = 0; m_k = 0; m_sz = 0;
        end else begin
            m_done = 0;
            if (mq.size() == 0) begin
                if (start) begin
                    m_sz = int'(psize); m_k = 0; m_r = 0;
                    if (psize == 2'b01) begin
                        mq.push_back('{{wdata[31:16], 16'h0}, 4'b0011, 2'd0});
                        mq.push_back('{{wdata[15:0], 16'h0}, 4'b0011, 2'd2});
                    end else if (psize == 2'b10) begin
                        mq.push_back('{{wdata[31:24], 24'h0}, 4'b0111, 2'd0});
                        mq.push_back('{{wdata[23:16], 24'h0}, 4'b0111, 2'd1});
                        mq.push_back('{{wdata[15:8], 24'h0}, 4'b0111, 2'd2});
                        mq.push_back('{{wdata[7:0], 24'h0}, 4'b0111, 2'd3});
                    end else begin
                        mq.push_back('{wdata, 4'b0000, 2'd0});
                    end
                end
            end else if (ack) begin
                if (m_sz == 1) begin
                    if (m_k == 0) m_r[31:16] = d_in[31:16];
                    else          m_r[15:0]  = d_in[31:16];
                end else if (m_sz == 2) begin
                    case (m_k)
                        0: m_r[31:24] = d_in[31:24];
                        1: m_r[23:16] = d_in[31:24];
                        2: m_r[15:8]  = d_in[31:24];
                        default: m_r[7:0] = d_in[31:24];
                    endcase
                end else begin
                    m_r = d_in;
                end
                void'(mq.pop_front());
                m_k++;
                if (mq.size() == 0) m_done = 1;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            cycles++;
            chk((!rst_n) ? "R1" : "R2", "xfer_o", {31'h0, xfer}, {31'h0, (mq.size() != 0)});
            if (mq.size() != 0) begin
                chk(wtag(), "wr_lanes_o", lanes, mq[0].d);
                chk(wtag(), "bs_n_o", {28'h0, bs_n}, {28'h0, mq[0].bs});
                chk(wtag(), "addr_o", {30'h0, addr}, {30'h0, mq[0].a});
            end else begin
                chk(wtag(), "wr_lanes_o idle", lanes, 32'h0);
                chk(wtag(), "bs_n_o idle", {28'h0, bs_n}, 32'hF);
                chk(wtag(), "addr_o idle", {30'h0, addr}, 32'h0);
            end
            chk((!rst_n) ? "R1" : "R9", "done_o", {31'h0, done}, {31'h0, m_done});
            chk((!rst_n) ? "R1" : "R8", "rdata_o", rdata, m_r);
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                summary();
            end
        end
    end

    // One access; stall_pct sets how often ack is withheld (R7);
    // spurious starts while busy must be ignored (R2)
    task automatic access(logic [1:0] sz, logic [31:0] w, int stall_pct, bit poke);
        int guard = 0;
        @(negedge clk);
        start = 1; psize = sz; wdata = w; ack = 0; d_in = $urandom;
        @(negedge clk);
        start = 0; wdata = $urandom;
        while (!done && guard < 400) begin
            ack   = (($urandom % 100) >= stall_pct);
            start = poke && (($urandom % 3) == 0);
            psize = 2'($urandom);
            d_in  = $urandom;
            guard++;
            @(negedge clk);
        end
        start = 0; ack = 0;
    endtask

    initial begin
        rst_n = 0; start = 0; psize = 0; wdata = 0; ack = 0; d_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        access(2'b00, 32'h1122_3344, 0, 0);   // R3
        access(2'b01, 32'hA1B2_C3D4, 0, 0);   // R4
        access(2'b10, 32'h0102_0304, 0, 0);   // R5
        access(2'b11, 32'hDEAD_BEEF, 0, 0);   // R6
        access(2'b10, 32'h55AA_F00F, 80, 1);  // R7 long stalls, R2 ignored starts
        access(2'b01, 32'hFFFF_0000, 60, 1);  // R8 read merge with stalls
        for (int n = 0; n < 60; n++)
            access(2'(n % 4), $urandom, int'($urandom % 70), 1);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule